// File: doc/BRIEF.md
# Fixed-Priority Task Scheduler Core

This block is the decision logic of a small preemptive kernel built in hardware. The task set is fixed when the block is configured. Each application task has a static priority parameter. Each interrupt line owns a proxy task that ranks above every application task. One idle task ranks below everything. The block keeps one ready flag per task and reports which task runs. That is always the highest-priority ready task. Ties between equal priorities go to the lower task identifier.

The running task talks to the block through a single service port. It can ask to make another task ready, or it can ask to end itself. Interrupt lines are latched as pending requests. A pending request is turned into an activation of its proxy only in a cycle with no service request, and only while no proxy is running. A running proxy therefore blocks all further interrupts until it ends itself. The running-task identifier and the error flag both come straight from registers.

Task identifiers are laid out as follows. Application tasks use 0 to NUM_APP-1. The proxy for interrupt line k uses NUM_APP+k. The idle task uses NUM_APP+NUM_IRQ. With the defaults (four application tasks with priorities 2, 5, 5, 1; two interrupt lines; 3-bit priorities), the proxies are 4 and 5 and the idle task is 6.

Top module: `sched_core`

## Requirements
- R1: During and after reset, only the idle task is ready, `run_id` shows the idle identifier, and `act_err` is 0.
- R2: After every event, `run_id` is the ready task with the highest priority. Among tasks of equal priority, the lowest identifier wins.
- R3: An activation (`svc_op`=0) of a task that is not ready sets its ready flag. The caller keeps running unless the target ranks strictly higher, in which case the target runs and the caller stays ready.
- R4: A terminate request (`svc_op`=1) clears the ready flag of the running task, and the next task is chosen by R2. If the idle task itself asks to terminate, nothing changes.
- R5: An activation of a task that is already ready, or of an identifier of NUM_APP+NUM_IRQ+1 or more, leaves every ready flag unchanged. It raises `act_err` for exactly the cycle after the request.
- R6: Each `irq_req` bit is latched as pending. One pending line is accepted per cycle, lowest line first. Acceptance makes proxy NUM_APP+k ready, and that proxy preempts any application task.
- R7: While a proxy task is running, no pending interrupt is accepted. The requests stay pending until the proxy ends.
- R8: In a cycle that carries a service request, no interrupt is accepted. The pending request is taken in a later cycle with no service request.
- R9: When no task other than the idle task is ready, `run_id` shows the idle task. It stays there until an activation or an interrupt.
- R10: `run_id` is registered. It changes only at the clock edge that ends a service-request cycle or an interrupt-acceptance cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| svc_valid | input | 1 | Service request from the running task this cycle |
| svc_op | input | 1 | 0 = activate `svc_target`, 1 = terminate the caller |
| svc_target | input | IDW | Task identifier to activate |
| irq_req | input | NUM_IRQ | Interrupt request per line, latched as pending |
| run_id | output | IDW | Identifier of the running task |
| act_err | output | 1 | One-cycle flag for an activation with no effect |

## Verification
Directed steps cover several cases in turn. One walks a lower-priority activation and a higher-priority preemption. Another activates an equal-priority task, which shows that ties are broken by the lower identifier. Further steps activate a task that is already ready and an identifier past the idle task, then raise an interrupt in the same cycle as a terminate. The last directed steps raise an interrupt while a proxy runs and drain every task back to idle. Together these separate the preemption rule, the tie rule, the error path, the service-over-interrupt ordering and the blockade. A long random run then mixes activations, terminates and interrupts on both lines. A bench model of ready flags and pending lines predicts every cycle, which exposes wrong ranking and lost or doubled interrupts in state combinations the directed steps do not reach.

// File: rtl/sched_pkg.sv
package sched_pkg;

   typedef enum logic {
      OP_ACTIVATE  = 1'b0,
      OP_TERMINATE = 1'b1
   } svc_op_e;

   function automatic int id_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/sched_irq_gate.sv
module sched_irq_gate #(
   parameter int NUM_IRQ = 2,
   localparam int LW = sched_pkg::id_bits(NUM_IRQ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_i,
   input  logic               allow_i,
   output logic               take_o,
   output logic [LW-1:0]      line_o
);

   logic [NUM_IRQ-1:0] pend_q, pend_d, clr;

   always_comb begin
      line_o = '0;
      for (int i = NUM_IRQ - 1; i >= 0; i--) begin
         if (pend_q[i]) line_o = LW'(i);
      end
      take_o = allow_i && (|pend_q);
      clr = '0;
      if (take_o) clr[line_o] = 1'b1;
      pend_d = (pend_q & ~clr) | irq_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   // R7 / R8: when acceptance is not allowed, no pending line is lost
   p_hold_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !allow_i |=> (($past(pend_q) & ~pend_q) == '0));

   // R6: the accepted line was pending
   p_take_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> pend_q[line_o]);

endmodule

// File: rtl/sched_ready_set.sv
module sched_ready_set #(
   parameter int NT  = 7,
   parameter int IDW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           act_i,
   input  logic           term_i,
   input  logic           irq_i,
   input  logic [IDW-1:0] act_id_i,
   input  logic [IDW-1:0] run_id_i,
   input  logic [IDW-1:0] irq_id_i,
   output logic [NT-1:0]  rdy_d_o,
   output logic [NT-1:0]  rdy_q_o,
   output logic           err_o
);

   localparam int IDLE = NT - 1;
   localparam logic [NT-1:0] RST_RDY = {1'b1, {(NT-1){1'b0}}};

   logic err_d;

   always_comb begin
      rdy_d_o = rdy_q_o;
      err_d   = 1'b0;
      if (act_i) begin
         if (int'(act_id_i) >= NT)       err_d = 1'b1;
         else if (rdy_q_o[act_id_i])     err_d = 1'b1;
         else                            rdy_d_o[act_id_i] = 1'b1;
      end else if (term_i) begin
         rdy_d_o[run_id_i] = 1'b0;
      end else if (irq_i) begin
         rdy_d_o[irq_id_i] = 1'b1;
      end
      rdy_d_o[IDLE] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy_q_o <= RST_RDY;
         err_o   <= 1'b0;
      end else begin
         rdy_q_o <= rdy_d_o;
         err_o   <= err_d;
      end
   end

   // R5: an error only follows an activation request
   p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(act_i));

   // R5: a rejected activation leaves every flag alone
   p_err_nochange_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> rdy_q_o == $past(rdy_q_o));

   // R4: terminate clears the caller unless the caller is idle
   p_term_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (term_i && !act_i && int'(run_id_i) != IDLE) |=> !rdy_q_o[$past(run_id_i)]);

endmodule

// File: rtl/sched_prio_pick.sv
module sched_prio_pick #(
   parameter int NUM_APP = 4,
   parameter int NUM_IRQ = 2,
   parameter int PRIO_W  = 3,
   parameter logic [NUM_APP*PRIO_W-1:0] APP_PRIO = '0,
   localparam int NT  = NUM_APP + NUM_IRQ + 1,
   localparam int IDW = sched_pkg::id_bits(NT)
) (
   input  logic [NT-1:0]  ready_i,
   output logic [IDW-1:0] win_o
);

   localparam int EPW = PRIO_W + 1;

   logic [EPW-1:0] eff [NT];
   logic [EPW-1:0] best;

   for (genvar g = 0; g < NT; g++) begin : g_eff
      if (g < NUM_APP) begin : g_app
         assign eff[g] = EPW'(APP_PRIO[g*PRIO_W +: PRIO_W]) + EPW'(1);
      end else if (g < NUM_APP + NUM_IRQ) begin : g_proxy
         assign eff[g] = '1;
      end else begin : g_idle
         assign eff[g] = '0;
      end
   end

   always_comb begin
      win_o = IDW'(NT - 1);
      best  = '0;
      for (int i = 0; i < NT - 1; i++) begin
         if (ready_i[i] && (eff[i] > best)) begin
            best  = eff[i];
            win_o = IDW'(i);
         end
      end
   end

endmodule

// File: rtl/sched_core.sv
module sched_core #(
   parameter int NUM_APP = 4,
   parameter int NUM_IRQ = 2,
   parameter int PRIO_W  = 3,
   parameter logic [NUM_APP*PRIO_W-1:0] APP_PRIO = {3'd1, 3'd5, 3'd5, 3'd2},
   localparam int NT  = NUM_APP + NUM_IRQ + 1,
   localparam int IDW = sched_pkg::id_bits(NT),
   localparam int LW  = sched_pkg::id_bits(NUM_IRQ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               svc_valid,
   input  logic               svc_op,
   input  logic [IDW-1:0]     svc_target,
   input  logic [NUM_IRQ-1:0] irq_req,
   output logic [IDW-1:0]     run_id,
   output logic               act_err
);

   import sched_pkg::*;

   localparam int IDLE = NT - 1;

   if (NUM_APP < 1) begin : g_chk_app
      $error("sched_core: NUM_APP must be at least 1");
   end
   if (NUM_IRQ < 1) begin : g_chk_irq
      $error("sched_core: NUM_IRQ must be at least 1");
   end
   if (PRIO_W < 1) begin : g_chk_pw
      $error("sched_core: PRIO_W must be at least 1");
   end

   svc_op_e         op;
   logic            do_act, do_term, proxy_run, allow, take;
   logic [LW-1:0]   line;
   logic [IDW-1:0]  irq_id, win;
   logic [NT-1:0]   rdy_d, rdy_q;
   logic [IDW-1:0]  run_q;

   assign op        = svc_op_e'(svc_op);
   assign do_act    = svc_valid && (op == OP_ACTIVATE);
   assign do_term   = svc_valid && (op == OP_TERMINATE);
   assign proxy_run = (run_q >= IDW'(NUM_APP)) && (run_q < IDW'(NUM_APP + NUM_IRQ));
   assign allow     = !svc_valid && !proxy_run;
   assign irq_id    = IDW'(NUM_APP) + IDW'(line);

   sched_irq_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_i   (irq_req),
      .allow_i (allow),
      .take_o  (take),
      .line_o  (line)
   );

   sched_ready_set #(.NT(NT), .IDW(IDW)) u_ready (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_i    (do_act),
      .term_i   (do_term),
      .irq_i    (take),
      .act_id_i (svc_target),
      .run_id_i (run_q),
      .irq_id_i (irq_id),
      .rdy_d_o  (rdy_d),
      .rdy_q_o  (rdy_q),
      .err_o    (act_err)
   );

   sched_prio_pick #(
      .NUM_APP  (NUM_APP),
      .NUM_IRQ  (NUM_IRQ),
      .PRIO_W   (PRIO_W),
      .APP_PRIO (APP_PRIO)
   ) u_pick (
      .ready_i (rdy_d),
      .win_o   (win)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= IDW'(IDLE);
      else        run_q <= win;
   end

   assign run_id = run_q;

   // R2: the reported task is always ready
   p_run_is_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_q[run_q]);

   // R7: a running proxy is not displaced without a service request
   p_proxy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (proxy_run && !svc_valid) |=> run_q == $past(run_q));

   // R9: with only the idle flag set, idle is reported
   p_idle_fallback_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_q == {1'b1, {(NT-1){1'b0}}}) |-> int'(run_q) == IDLE);

   // R10: output moves only after a request or an acceptance
   p_moves_on_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q != $past(run_q)) |-> $past(svc_valid || take));

endmodule

// File: tb/sim_sched_core.sv
`timescale 1ns/1ps
module sim_sched_core;

   localparam int NUM_APP = 4;
   localparam int NUM_IRQ = 2;
   localparam int PRIO_W  = 3;
   localparam int NT      = NUM_APP + NUM_IRQ + 1;
   localparam int IDLE    = NT - 1;
   localparam logic [NUM_APP*PRIO_W-1:0] PRIO = {3'd1, 3'd5, 3'd5, 3'd2};

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               svc_valid = 1'b0;
   logic               svc_op = 1'b0;
   logic [2:0]         svc_target = '0;
   logic [NUM_IRQ-1:0] irq_req = '0;
   logic [2:0]         run_id;
   logic               act_err;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   logic [NT-1:0]      m_rdy;
   logic [NUM_IRQ-1:0] m_pend;
   int                 m_run;
   logic               m_err;

   always #2.5 clk = ~clk;

   sched_core #(
      .NUM_APP (NUM_APP),
      .NUM_IRQ (NUM_IRQ),
      .PRIO_W  (PRIO_W),
      .APP_PRIO(PRIO)
   ) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .svc_valid  (svc_valid),
      .svc_op     (svc_op),
      .svc_target (svc_target),
      .irq_req    (irq_req),
      .run_id     (run_id),
      .act_err    (act_err)
   );

   // rank: idle lowest, application p ranks as p+1, proxies above all
   function automatic int rank(input int id);
      if (id < NUM_APP) return int'(PRIO[id*PRIO_W +: PRIO_W]) + 1;
      if (id < NUM_APP + NUM_IRQ) return 100;
      return 0;
   endfunction

   function automatic int pick(input logic [NT-1:0] r);
      int best = IDLE;
      int bp = 0;
      for (int i = 0; i < NT - 1; i++) begin
         if (r[i] && rank(i) > bp) begin
            bp = rank(i);
            best = i;
         end
      end
      return best;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // called at a falling edge; drives one cycle and checks the result
   task automatic step(input logic v, input logic op, input int tgt,
                       input logic [NUM_IRQ-1:0] irq, input string tag);
      logic [NT-1:0]      n_rdy;
      logic [NUM_IRQ-1:0] n_pend;
      logic               n_err;
      bit                 acc;
      int                 line;
      svc_valid  = v;
      svc_op     = op;
      svc_target = 3'(tgt);
      irq_req    = irq;
      n_rdy  = m_rdy;
      n_pend = m_pend;
      n_err  = 1'b0;
      acc  = !v && !(m_run >= NUM_APP && m_run < NUM_APP + NUM_IRQ) && (|m_pend);
      line = m_pend[0] ? 0 : 1;
      if (v && !op) begin
         if (tgt >= NT || m_rdy[tgt]) n_err = 1'b1;
         else n_rdy[tgt] = 1'b1;
      end else if (v && op) begin
         if (m_run != IDLE) n_rdy[m_run] = 1'b0;
      end else if (acc) begin
         n_rdy[NUM_APP + line] = 1'b1;
         n_pend[line] = 1'b0;
      end
      n_pend = n_pend | irq;
      #1;
      chk("R10 output held before edge", int'(run_id), m_run);
      @(posedge clk);
      #1;
      m_rdy  = n_rdy;
      m_pend = n_pend;
      m_err  = n_err;
      m_run  = pick(m_rdy);
      chk({tag, " run_id"}, int'(run_id), m_run);
      chk({tag, " act_err"}, int'(act_err), int'(m_err));
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5EED));
      m_rdy  = 7'b1000000;
      m_pend = '0;
      m_run  = IDLE;
      m_err  = 1'b0;
      repeat (4) @(posedge clk);
      #1;
      chk("R1 run_id in reset", int'(run_id), IDLE);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 run_id after reset", int'(run_id), IDLE);
      chk("R1 act_err after reset", int'(act_err), 0);
      @(negedge clk);

      step(0, 0, 0, 2'b00, "R9 idle stays");
      step(1, 0, 0, 2'b00, "R3 activate from idle");
      step(1, 0, 3, 2'b00, "R3 lower target keeps caller");
      step(1, 0, 1, 2'b00, "R3 higher target preempts");
      step(1, 0, 2, 2'b00, "R2 equal priority lower id wins");
      step(1, 0, 1, 2'b00, "R5 already ready");
      step(0, 0, 0, 2'b00, "R5 error lasts one cycle");
      step(1, 0, 7, 2'b00, "R5 identifier out of range");
      step(1, 1, 0, 2'b10, "R8 service beats interrupt");
      step(0, 0, 0, 2'b00, "R6 pending proxy preempts");
      step(0, 0, 0, 2'b01, "R7 interrupt during proxy");
      step(0, 0, 0, 2'b00, "R7 still blocked");
      step(1, 1, 0, 2'b00, "R4 proxy terminates");
      step(0, 0, 0, 2'b00, "R6 held line accepted");
      step(1, 1, 0, 2'b00, "R4 terminate proxy");
      step(1, 1, 0, 2'b00, "R4 terminate task");
      step(1, 1, 0, 2'b00, "R4 terminate task");
      step(1, 1, 0, 2'b00, "R4 terminate last task");
      step(0, 0, 0, 2'b00, "R9 idle when none ready");
      step(1, 1, 0, 2'b00, "R4 idle terminate ignored");
      step(1, 0, 6, 2'b00, "R5 activate idle");
      step(0, 0, 0, 2'b11, "R6 two lines lowest first");
      step(0, 0, 0, 2'b00, "R7 second line blocked");
      step(1, 1, 0, 2'b00, "R4 first proxy ends");
      step(0, 0, 0, 2'b00, "R6 second proxy accepted");
      step(1, 1, 0, 2'b00, "R4 second proxy ends");

      for (int n = 0; n < 3000; n++) begin
         logic v = ($urandom % 10) < 4;
         logic op = $urandom % 2;
         int tgt = int'($urandom % 8);
         logic [NUM_IRQ-1:0] irq;
         irq[0] = ($urandom % 10) == 0;
         irq[1] = ($urandom % 10) == 0;
         step(v, op, tgt, irq, "R2 random mix");
      end

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule